// File: doc/BRIEF.md
# Rolling-Key Watchdog Timer

This block is a watchdog that counts down once per clock. Software arms it through a control write, which carries the timeout length. It keeps it alive through service writes of a key. The key changes on every successful service. The value expected after arming is the constant `KEY_INIT`, which defaults to 0xA5A5A5A5. After each accepted service, the next expected key is the bitwise complement of the word just written. Stale software that repeats the same value therefore cannot keep the timer alive.

A bite occurs when the count runs out or when a wrong key is presented. On a bite, the block drives `sys_rst_o` high for `BITE_CYC` clocks. It also reloads the count from the stored timeout and puts the expected key back to its initial value. A timeout of zero switches the watchdog off. The expected key and the remaining count are brought out on ports so that tests can observe them.

Top module: `wdt_rollkey`

## Requirements
- R1: After reset, `sys_rst_o` is 0, `count_o` is 0, `key_o` equals `KEY_INIT` (0xA5A5A5A5), and the watchdog is disabled.
- R2: A control write (`ctl_we`=1) stores `ctl_wdata` as the timeout. On the next cycle, `count_o` equals that value and `key_o` equals `KEY_INIT`.
- R3: While enabled and with no write, `count_o` decreases by exactly one per clock while it is above 1.
- R4: A timeout of 0 disables the watchdog. `count_o` stays 0, no bite occurs, and service writes of any value leave `key_o` and `sys_rst_o` unchanged.
- R5: A service write (`key_we`=1) whose data equals `key_o` reloads `count_o` with the stored timeout on the next cycle.
- R6: After an accepted service, `key_o` becomes the bitwise inverse of the value written.
- R7: A service write whose data differs from `key_o` while enabled raises `sys_rst_o` on the next cycle.
- R8: When the count is 1 in an enabled clock with no write, the next cycle brings a bite: `sys_rst_o` rises.
- R9: Every bite holds `sys_rst_o` high for exactly `BITE_CYC` (16) consecutive clocks. It also reloads `count_o` with the timeout and restores `key_o` to `KEY_INIT`.
- R10: A control write and a service write in the same cycle act as a control write alone. The service data is not compared and has no effect.
- R11: A bite while `sys_rst_o` is already high restarts the full `BITE_CYC` window from that bite.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | CNT_W | Timeout value for a control write; 0 disables |
| key_we | input | 1 | Service write strobe |
| key_wdata | input | KEY_W | Service key value |
| sys_rst_o | output | 1 | System reset request, high during a bite |
| key_o | output | KEY_W | Currently expected service key |
| count_o | output | CNT_W | Remaining count |

## Verification
The countdown is first left to run out unattended, which separates the expiry bite from any key logic. It is then serviced with the alternating key sequence 0xA5A5A5A5, 0x5A5A5A5A, 0xA5A5A5A5. That sequence tells a rolling complement apart from a fixed kick value. Wrong keys are written, including a repeat of the previous good key and a second wrong key inside an active pulse, to pin the bite delay, its length and the window restart. The disabled state, and a control write coinciding with a service write, show which writes are ignored.

// File: rtl/wdt_rollkey.sv
module wdt_rollkey #(
  parameter int CNT_W = 16,
  parameter int KEY_W = 32,
  parameter logic [KEY_W-1:0] KEY_INIT = 32'hA5A5A5A5,
  parameter int BITE_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CNT_W-1:0] ctl_wdata,
  input  logic             key_we,
  input  logic [KEY_W-1:0] key_wdata,
  output logic             sys_rst_o,
  output logic [KEY_W-1:0] key_o,
  output logic [CNT_W-1:0] count_o
);

  localparam int PW = $clog2(BITE_CYC + 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] trig_q, cnt_q;
  logic [KEY_W-1:0] key_q;
  logic [PW-1:0]    pulse_q;

  wire en     = |trig_q;
  wire svc_in = key_we && !ctl_we && en;
  wire key_ok = key_wdata == key_q;
  wire serve  = svc_in && key_ok;
  wire bad    = svc_in && !key_ok;
  wire expire = en && !ctl_we && !key_we && (cnt_q == ONE);
  wire bite   = bad || expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      cnt_q  <= '0;
      key_q  <= KEY_INIT;
    end else if (ctl_we) begin
      trig_q <= ctl_wdata;
      cnt_q  <= ctl_wdata;
      key_q  <= KEY_INIT;
    end else if (bite) begin
      cnt_q  <= trig_q;
      key_q  <= KEY_INIT;
    end else if (serve) begin
      cnt_q  <= trig_q;
      key_q  <= ~key_wdata;
    end else if (en) begin
      cnt_q  <= cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pulse_q <= '0;
    else if (bite)           pulse_q <= PW'(BITE_CYC);
    else if (pulse_q != '0)  pulse_q <= pulse_q - PW'(1);
  end

  assign sys_rst_o = pulse_q != '0;
  assign key_o     = key_q;
  assign count_o   = cnt_q;

  // R2
  ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (count_o == $past(ctl_wdata)) && (key_o == KEY_INIT));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ctl_we && !key_we && count_o > ONE) |=> count_o == $past(count_o) - ONE);

  // R4
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ctl_we) |=> $stable(count_o) && $stable(key_o));

  // R6
  key_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serve |=> key_o == ~$past(key_wdata));

  // R7
  bad_key_bite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> sys_rst_o && key_o == KEY_INIT);

  // R8
  expire_bite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> sys_rst_o && count_o == $past(trig_q));

  // R9
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_o && pulse_q > PW'(1)) |=> sys_rst_o);

endmodule

// File: tb/test_wdt_rollkey.sv
module test_wdt_rollkey;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int KEY_W = 32;
  localparam logic [31:0] KINIT = 32'hA5A5A5A5;
  localparam int BITE = 16;

  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, key_we = 0;
  logic [CNT_W-1:0] ctl_wdata = '0;
  logic [KEY_W-1:0] key_wdata = '0;
  logic sys_rst_o;
  logic [KEY_W-1:0] key_o;
  logic [CNT_W-1:0] count_o;

  wdt_rollkey #(.CNT_W(CNT_W), .KEY_W(KEY_W), .KEY_INIT(KINIT), .BITE_CYC(BITE)) i_wdt_rollkey (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .key_we(key_we), .key_wdata(key_wdata),
    .sys_rst_o(sys_rst_o), .key_o(key_o), .count_o(count_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int m_trig = 0, m_cnt = 0, m_pulse = 0;
  logic [31:0] m_key = KINIT;
  int n_cmp = 0, n_bad = 0, cycles = 0;
  string req = "R1";
  bit done = 0;

  // behavioural reference
  always @(posedge clk) begin
    if (!rst_n) begin
      m_trig = 0; m_cnt = 0; m_key = KINIT; m_pulse = 0;
    end else begin
      bit b;
      b = 0;
      if (m_pulse > 0) m_pulse--;
      if (ctl_we) begin                      // R10: control wins
        m_trig = int'(ctl_wdata); m_cnt = m_trig; m_key = KINIT;
      end else if (m_trig != 0) begin
        if (key_we) begin
          if (key_wdata == m_key) begin m_cnt = m_trig; m_key = ~key_wdata; end
          else b = 1;
        end else if (m_cnt == 1) b = 1;
        else m_cnt--;
      end
      if (b) begin m_pulse = BITE; m_cnt = m_trig; m_key = KINIT; end
    end
  end

  task automatic chk(string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      chk("sys_rst_o", longint'(sys_rst_o), longint'(m_pulse > 0));
      chk("key_o", longint'(key_o), longint'(m_key));
      chk("count_o", longint'(count_o), longint'(m_cnt));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(int v);
    @(negedge clk); ctl_we = 1; ctl_wdata = CNT_W'(v);
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic wr_key(logic [31:0] v);
    @(negedge clk); key_we = 1; key_wdata = v;
    @(negedge clk); key_we = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    req = "R1"; idle(3);
    rst_n = 1; idle(3);                       // R1 reset state, disabled
    req = "R2"; wr_ctl(5);                    // R2 load
    req = "R3"; idle(2);                      // R3 decrement
    req = "R8"; idle(4);                      // R8 expiry bite
    req = "R9"; idle(18);                     // R9 16-cycle pulse, reload
    req = "R2"; wr_ctl(20);
    req = "R5"; idle(3); wr_key(32'hA5A5A5A5); // R5 reload
    req = "R6"; idle(2); wr_key(32'h5A5A5A5A); // R6 inverse key
    idle(2); wr_key(32'hA5A5A5A5); idle(2);
    req = "R7"; wr_key(32'hA5A5A5A5);         // R7 stale key bites
    idle(5);
    req = "R11"; wr_key(32'h12345678);        // R11 restart window
    idle(20);
    req = "R10"; @(negedge clk);              // R10 simultaneous writes
    ctl_we = 1; ctl_wdata = 16'd9; key_we = 1; key_wdata = 32'hDEADBEEF;
    @(negedge clk); ctl_we = 0; key_we = 0; idle(3);
    req = "R4"; wr_ctl(0);                    // R4 disabled
    wr_key(32'h0BADF00D); idle(3); wr_key(32'hA5A5A5A5); idle(5);
    req = "R9"; wr_ctl(3); idle(25);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end
endmodule